// File: doc/BRIEF.md
# Successive Integration Conversion Sequencer

This block is the digital controller of a dual-slope integrating converter that is refined with successive integration and digital auto-zero. It steps the analog section through its phases and reports the current phase to the switch drivers. It also uses the integrator comparator to gate a six-decade ten's-complement BCD accumulator. Each conversion runs two passes. The first pass measures the input. The second pass runs with the inputs shorted and measures the amplifier offset. The second reading is subtracted from the first, and the difference is published as sign and BCD magnitude.

Within a pass, a first de-integration counts at the hundreds position. Two further de-integrations then follow, each preceded by a settle interval and a times-ten residue interval. The second counts in the opposite direction at the tens position. The third counts in the original direction at the units position. The polarity seen at the end of integration picks the reference direction and the sign of every count in that pass. A de-integration that never sees the crossing is cut off at the integrate length plus ten percent, and the conversion is then flagged as saturated.

The block runs on the oscillator clock. A prescaler produces one converter tick every `CLK_DIV` oscillator cycles, and every duration is counted in ticks.

Top module: `succ_int_seq`

## Requirements
- R1: The integrate phase lasts `INT_SHORT` ticks when `range_i` is 1 and `INT_LONG` ticks when `range_i` is 0 (defaults 1000 and 10000). `range_i` is sampled as the first pass leaves zero-integrate, and the value is kept for both passes.
- R2: A converter tick occurs once every `CLK_DIV` clocks (default 2). `phase_o` changes only on a tick, so every phase lasts a whole number of ticks times `CLK_DIV` clocks.
- R3: `phase_o` encodes zero-integrate=0, integrate=1, de-int A=2, rest A=3, times-ten A=4, de-int B=5, rest B=6, times-ten B=7, de-int C=8, latch=9. A pass runs 0 through 8 in order. The first pass has `short_o`=0 and is followed by a second pass with `short_o`=1. The second pass is followed by latch, then a new first pass.
- R4: In a de-int phase, each tick with `cmp_i`=1 counts once. The first tick with `cmp_i`=0 ends the phase without counting. For a positive first-pass reading, de-int A adds 100 per count, de-int B subtracts 10 per count and de-int C adds 1 per count.
- R5: `pol_i` (1 = negative input) is sampled on the last integrate tick of each pass and drives `ref_neg_o` for that pass. A value of 1 negates the sign of every count in that pass.
- R6: The published result equals the first-pass reading minus the shorted-pass reading.
- R7: `res_o` is the BCD magnitude, with the units digit in bits 3:0 and each higher decade four bits above the previous one. `neg_o` is 1 only for a nonzero negative result.
- R8: A de-int phase still seeing `cmp_i`=1 after `INT+INT/10` counts ends on the next tick without counting. `sat_o` is then 1 for that conversion's result and 0 for a conversion without such a timeout.
- R9: Zero-integrate lasts `ZI_LEN` ticks, each rest phase `REST_LEN` ticks, and each times-ten phase `X10_LEN` ticks.
- R10: `done_o` is a one-clock pulse on the edge where the result outputs update. `latch_o` is 1 for the whole latch phase, which lasts `LATCH_LEN` ticks. The result outputs hold between updates.
- R11: While `rst` is high, `phase_o`=0 and `short_o`, `done_o`, `latch_o`, `sat_o`, `neg_o` and `res_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| range_i | input | 1 | 1 selects the short integrate, 0 the long one |
| cmp_i | input | 1 | Comparator: 1 while the integrator has not yet crossed zero |
| pol_i | input | 1 | Input sign, 1 = negative |
| phase_o | output | 4 | Current phase code |
| short_o | output | 1 | Inputs-shorted (offset) pass active |
| ref_neg_o | output | 1 | Reference polarity select for de-integration |
| res_o | output | 24 | BCD magnitude of the corrected result |
| neg_o | output | 1 | Result sign |
| sat_o | output | 1 | A de-integration timed out in this conversion |
| done_o | output | 1 | One-clock pulse when the result updates |
| latch_o | output | 1 | Latch strobe, high during the latch phase |

## Verification
The bench builds the block with `CLK_DIV`=2, `INT_LONG`=40, `INT_SHORT`=10, zero-integrate 5, rest 3, times-ten 4 and latch 3 ticks. At these lengths a full two-pass conversion takes a few hundred clocks. Both timeout limits (44 and 11 counts) can be reached by a comparator model that holds `cmp_i` for a chosen number of ticks. Many conversions of both ranges, both polarities and both offset signs fit in one run. These include saturation in single passes, offset readings larger than the input reading, and equal readings that must give a non-negative zero.

// File: rtl/sis_pkg.sv
package sis_pkg;
  typedef enum logic [3:0] {
    PH_ZI    = 4'd0,
    PH_INT   = 4'd1,
    PH_DE1   = 4'd2,
    PH_REST1 = 4'd3,
    PH_X10A  = 4'd4,
    PH_DE2   = 4'd5,
    PH_REST2 = 4'd6,
    PH_X10B  = 4'd7,
    PH_DE3   = 4'd8,
    PH_LATCH = 4'd9
  } phase_e;

  localparam int NDIG = 6;
  localparam int DIGW = 4;
endpackage

// File: rtl/sis_tick.sv
module sis_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || cnt_q == CW'(DIV - 1)) cnt_q <= '0;
        else                              cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(DIV - 1));

      // two ticks never sit on adjacent clocks when dividing
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/sis_bcd_acc.sv
module sis_bcd_acc #(
  parameter int NDIG = 6,
  localparam int PW  = (NDIG > 1) ? $clog2(NDIG) : 1,
  localparam int W   = NDIG * 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          down_i,
  input  logic [PW-1:0] pos_i,
  output logic [W-1:0]  dig_o
);
  logic [W-1:0] dig_q, dig_n;

  // +/-1 applied at decade pos_i, ripple to the decades above
  always_comb begin
    logic cy;
    logic hit;
    logic [3:0] d;
    cy    = 1'b0;
    dig_n = dig_q;
    for (int i = 0; i < NDIG; i++) begin
      d   = dig_q[i*4 +: 4];
      hit = (i == int'(pos_i)) || cy;
      cy  = 1'b0;
      if (hit) begin
        if (down_i) begin
          if (d == 4'd0) begin dig_n[i*4 +: 4] = 4'd9; cy = 1'b1; end
          else                 dig_n[i*4 +: 4] = d - 4'd1;
        end else begin
          if (d == 4'd9) begin dig_n[i*4 +: 4] = 4'd0; cy = 1'b1; end
          else                 dig_n[i*4 +: 4] = d + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) dig_q <= '0;
    else if (en_i)    dig_q <= dig_n;
  end

  assign dig_o = dig_q;

  assert_acc_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> $stable(dig_q));

  generate
    for (genvar g = 0; g < NDIG; g++) begin : g_chk
      assert_digit_legal_R7: assert property (@(posedge clk) disable iff (rst)
        dig_q[g*4 +: 4] <= 4'd9);
    end
  endgenerate
endmodule

// File: rtl/sis_bcd_sign.sv
module sis_bcd_sign #(
  parameter int NDIG = 6,
  localparam int W   = NDIG * 4
) (
  input  logic [W-1:0] tc_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);
  logic [W-1:0] cmp_n;

  // ten's complement of the accumulator: nines' complement plus one
  always_comb begin
    logic cy;
    logic [3:0] d;
    cy = 1'b1;
    for (int i = 0; i < NDIG; i++) begin
      d = 4'd9 - tc_i[i*4 +: 4];
      if (cy && d == 4'd9) begin
        cmp_n[i*4 +: 4] = 4'd0;
      end else if (cy) begin
        cmp_n[i*4 +: 4] = d + 4'd1;
        cy = 1'b0;
      end else begin
        cmp_n[i*4 +: 4] = d;
      end
    end
  end

  assign neg_o = (tc_i[W-1 -: 4] >= 4'd5);
  assign mag_o = neg_o ? cmp_n : tc_i;
endmodule

// File: rtl/succ_int_seq.sv
module succ_int_seq #(
  parameter int INT_LONG  = 10000,
  parameter int INT_SHORT = 1000,
  parameter int ZI_LEN    = 200,
  parameter int REST_LEN  = 100,
  parameter int X10_LEN   = 100,
  parameter int LATCH_LEN = 100,
  parameter int CLK_DIV   = 2,
  localparam int NDIG     = sis_pkg::NDIG,
  localparam int W        = NDIG * 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         range_i,
  input  logic         cmp_i,
  input  logic         pol_i,
  output logic [3:0]   phase_o,
  output logic         short_o,
  output logic         ref_neg_o,
  output logic [W-1:0] res_o,
  output logic         neg_o,
  output logic         sat_o,
  output logic         done_o,
  output logic         latch_o
);
  import sis_pkg::*;

  localparam int DE_LONG  = INT_LONG + INT_LONG / 10;
  localparam int DE_SHORT = INT_SHORT + INT_SHORT / 10;
  localparam int TW = $clog2(DE_LONG + DE_SHORT + ZI_LEN + REST_LEN + X10_LEN + LATCH_LEN + 1);
  localparam int PW = (NDIG > 1) ? $clog2(NDIG) : 1;

  phase_e        phase_q;
  logic          short_q, pol_q, range_q, sat_run_q;
  logic [TW-1:0] tcnt_q, len_c, dmax_c;
  logic [W-1:0]  res_q, acc_dig, mag_c;
  logic          neg_q, sat_q, done_q, latch_q, neg_c;
  logic          tick, is_de, de_hit, de_end, adv, cnt_en, cnt_down, acc_clr;
  logic [PW-1:0] cnt_pos;

  sis_tick #(.DIV(CLK_DIV)) tick_i (.clk(clk), .rst(rst), .tick_o(tick));

  always_comb begin
    case (phase_q)
      PH_ZI:             len_c = TW'(ZI_LEN);
      PH_INT:            len_c = range_q ? TW'(INT_SHORT) : TW'(INT_LONG);
      PH_REST1, PH_REST2: len_c = TW'(REST_LEN);
      PH_X10A, PH_X10B:  len_c = TW'(X10_LEN);
      default:           len_c = TW'(LATCH_LEN);
    endcase
    case (phase_q)
      PH_DE1:  cnt_pos = PW'(2);
      PH_DE2:  cnt_pos = PW'(1);
      default: cnt_pos = PW'(0);
    endcase
  end

  assign dmax_c   = range_q ? TW'(DE_SHORT) : TW'(DE_LONG);
  assign is_de    = (phase_q == PH_DE1) || (phase_q == PH_DE2) || (phase_q == PH_DE3);
  assign de_hit   = cmp_i && (tcnt_q == dmax_c);
  assign de_end   = !cmp_i || de_hit;
  assign adv      = tick && (is_de ? de_end : (tcnt_q == len_c - 1'b1));
  assign cnt_en   = tick && is_de && !de_end;
  assign cnt_down = (phase_q == PH_DE2) ^ pol_q ^ short_q;
  assign acc_clr  = adv && (phase_q == PH_LATCH);

  sis_bcd_acc #(.NDIG(NDIG)) acc_i (
    .clk(clk), .rst(rst), .clr_i(acc_clr), .en_i(cnt_en),
    .down_i(cnt_down), .pos_i(cnt_pos), .dig_o(acc_dig)
  );

  sis_bcd_sign #(.NDIG(NDIG)) sign_i (.tc_i(acc_dig), .mag_o(mag_c), .neg_o(neg_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_ZI;
      short_q   <= 1'b0;
      pol_q     <= 1'b0;
      range_q   <= 1'b0;
      tcnt_q    <= '0;
      sat_run_q <= 1'b0;
      res_q     <= '0;
      neg_q     <= 1'b0;
      sat_q     <= 1'b0;
      done_q    <= 1'b0;
      latch_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick && !adv) begin
        tcnt_q <= tcnt_q + 1'b1;
      end else if (adv) begin
        tcnt_q <= '0;
        if (is_de && de_hit) sat_run_q <= 1'b1;
        case (phase_q)
          PH_ZI: begin
            phase_q <= PH_INT;
            if (!short_q) range_q <= range_i;
          end
          PH_INT: begin
            phase_q <= PH_DE1;
            pol_q   <= pol_i;
          end
          PH_DE1:   phase_q <= PH_REST1;
          PH_REST1: phase_q <= PH_X10A;
          PH_X10A:  phase_q <= PH_DE2;
          PH_DE2:   phase_q <= PH_REST2;
          PH_REST2: phase_q <= PH_X10B;
          PH_X10B:  phase_q <= PH_DE3;
          PH_DE3: begin
            if (!short_q) begin
              phase_q <= PH_ZI;
              short_q <= 1'b1;
            end else begin
              phase_q <= PH_LATCH;
              res_q   <= mag_c;
              neg_q   <= neg_c;
              sat_q   <= sat_run_q | de_hit;
              done_q  <= 1'b1;
              latch_q <= 1'b1;
            end
          end
          default: begin
            phase_q   <= PH_ZI;
            short_q   <= 1'b0;
            latch_q   <= 1'b0;
            sat_run_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign phase_o   = phase_q;
  assign short_o   = short_q;
  assign ref_neg_o = pol_q;
  assign res_o     = res_q;
  assign neg_o     = neg_q;
  assign sat_o     = sat_q;
  assign done_o    = done_q;
  assign latch_o   = latch_q;

  assert_phase_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase_q));
  assert_offset_pass_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(short_q) |-> (phase_q == PH_ZI));
  assert_de_window_R8: assert property (@(posedge clk) disable iff (rst)
    is_de |-> (tcnt_q <= dmax_c));
  assert_done_in_latch_R10: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (phase_q == PH_LATCH) && latch_q);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_no_neg_zero_R7: assert property (@(posedge clk) disable iff (rst)
    neg_q |-> (res_q != '0));
endmodule

// File: tb/succ_int_seq_tb.sv
module succ_int_seq_tb_top;
  localparam int DIV = 2;
  localparam int IL = 40, IS = 10, ZI = 5, RS = 3, XT = 4, LT = 3;

  logic clk = 1'b0, rst = 1'b1, range_i = 1'b0, cmp_i = 1'b0, pol_i = 1'b0;
  logic [3:0] phase_o;
  logic short_o, ref_neg_o, neg_o, sat_o, done_o, latch_o;
  logic [23:0] res_o;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  int tgt[2][3];
  bit tpol[2];
  logic [23:0] prev_res = '0;

  always #5 clk = ~clk;

  succ_int_seq #(.INT_LONG(IL), .INT_SHORT(IS), .ZI_LEN(ZI), .REST_LEN(RS),
                 .X10_LEN(XT), .LATCH_LEN(LT), .CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .range_i(range_i), .cmp_i(cmp_i), .pol_i(pol_i),
    .phase_o(phase_o), .short_o(short_o), .ref_neg_o(ref_neg_o), .res_o(res_o),
    .neg_o(neg_o), .sat_o(sat_o), .done_o(done_o), .latch_o(latch_o));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int dmax();
    return range_i ? (IS + IS / 10) : (IL + IL / 10);
  endfunction

  function automatic int clip(input int n);
    return (n > dmax()) ? dmax() : n;
  endfunction

  function automatic bit is_de(input int p);
    return p == 2 || p == 5 || p == 8;
  endfunction

  function automatic int de_idx(input int p);
    return (p == 2) ? 0 : (p == 5) ? 1 : 2;
  endfunction

  function automatic int exp_len(input int p, input bit s);
    case (p)
      0: return ZI;
      1: return range_i ? IS : IL;
      3, 6: return RS;
      4, 7: return XT;
      9: return LT;
      default: return clip(tgt[s][de_idx(p)]) + 1;
    endcase
  endfunction

  // phase sequence, duration and comparator/polarity model
  initial begin
    int c = 0, lastp = 0, np;
    bit lasts = 0, first = 1, ns;
    string tag;
    forever begin
      @(negedge clk);
      if (rst) begin
        c = 0; lastp = int'(phase_o); lasts = short_o; first = 1; cmp_i = 1'b0;
      end else begin
        if (int'(phase_o) != lastp || short_o != lasts) begin
          ns = lasts;
          if (lastp == 8) begin np = lasts ? 9 : 0; ns = 1'b1; end
          else if (lastp == 9) begin np = 0; ns = 1'b0; end
          else np = lastp + 1;
          chk(int'(phase_o) == np && short_o == ns, "R3", "next phase code",
              int'(phase_o) + 16 * short_o, np + 16 * ns);
          if (!first) begin
            tag = (lastp == 1) ? "R1 R2" : is_de(lastp) ? "R4 R8 R2" :
                  (lastp == 9) ? "R10 R2" : "R9 R2";
            chk(c + 1 == exp_len(lastp, lasts) * DIV, tag, "phase clocks",
                c + 1, exp_len(lastp, lasts) * DIV);
          end
          first = 0; c = 0; lastp = int'(phase_o); lasts = short_o;
        end else c++;
        pol_i = tpol[short_o];
        cmp_i = is_de(int'(phase_o)) && (c < tgt[short_o][de_idx(int'(phase_o))] * DIV);
      end
    end
  end

  task automatic run_conv(input bit rng, input int a0, b0, c0, input bit p0,
                          input int a1, b1, c1, input bit p1, input string lbl);
    int v, m;
    bit es;
    logic [23:0] er;
    range_i = rng;
    tgt[0][0] = a0; tgt[0][1] = b0; tgt[0][2] = c0; tpol[0] = p0;
    tgt[1][0] = a1; tgt[1][1] = b1; tgt[1][2] = c1; tpol[1] = p1;
    v = (p0 ? -1 : 1) * (100 * clip(a0) - 10 * clip(b0) + clip(c0))
      - (p1 ? -1 : 1) * (100 * clip(a1) - 10 * clip(b1) + clip(c1));
    es = a0 > dmax() || b0 > dmax() || c0 > dmax() ||
         a1 > dmax() || b1 > dmax() || c1 > dmax();
    m = (v < 0) ? -v : v;
    er = '0;
    for (int k = 0; k < 6; k++) begin
      er[k*4 +: 4] = 4'(m % 10);
      m = m / 10;
    end
    repeat (20) @(negedge clk);
    chk(res_o == prev_res, "R10", {lbl, " result held"}, res_o, prev_res);
    while (!done_o) @(negedge clk);
    chk(res_o == er, "R4 R6 R7", {lbl, " magnitude"}, res_o, er);
    chk(neg_o == (v < 0), "R5 R7", {lbl, " sign"}, neg_o, v < 0);
    chk(sat_o == es, "R8", {lbl, " saturation"}, sat_o, es);
    chk(latch_o == 1'b1, "R10", {lbl, " latch at done"}, latch_o, 1);
    prev_res = er;
    @(negedge clk);
    chk(done_o == 1'b0, "R10", {lbl, " done width"}, done_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    tgt[0] = '{0, 0, 0}; tgt[1] = '{0, 0, 0}; tpol = '{0, 0};
    repeat (4) @(negedge clk);
    chk(phase_o == 4'd0 && short_o == 0 && done_o == 0 && latch_o == 0,
        "R11", "reset control", {phase_o, short_o, done_o, latch_o}, 0);
    chk(res_o == 0 && neg_o == 0 && sat_o == 0, "R11", "reset result",
        {res_o, neg_o, sat_o}, 0);
    rst = 1'b0;
    run_conv(0, 12, 5, 7, 0, 0, 0, 0, 0, "plain positive R4");
    run_conv(1, 3, 2, 9, 1, 0, 1, 0, 0, "negative input R5");
    run_conv(0, 2, 3, 4, 0, 2, 3, 4, 0, "equal readings R7");
    run_conv(1, 0, 1, 2, 0, 1, 0, 0, 0, "offset exceeds R6");
    run_conv(1, 15, 1, 1, 0, 0, 0, 0, 0, "timeout first R8");
    run_conv(0, 5, 0, 50, 1, 0, 0, 0, 0, "timeout last R8");
    run_conv(0, 0, 0, 0, 0, 0, 0, 0, 1, "all zero R6");
    run_conv(1, 11, 0, 0, 0, 0, 0, 0, 1, "limit exact R8");
    for (int n = 0; n < 8; n++) begin
      run_conv(1'($urandom_range(0, 1)), $urandom_range(0, 46), $urandom_range(0, 12),
               $urandom_range(0, 12), 1'($urandom_range(0, 1)),
               $urandom_range(0, 2), $urandom_range(0, 3), $urandom_range(0, 3),
               1'($urandom_range(0, 1)), "random R6");
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule